// File: doc/BRIEF.md
# Class-D Bridge Protection Controller

This block is the digital supervisor that sits between a PWM modulator and the gate drivers of a two-channel full-bridge class-D output stage. Each channel has a plus and a minus half-bridge, and each half-bridge gets a high-side enable and a low-side enable. When nothing is wrong, each half-bridge copies its PWM input: the high side is on while the input is high and the low side is on while it is low. When the bridge must be silent, both sides are off and the output floats.

The outputs are gated by the run (standby) and play (mute) controls and by five protections. These are a per-channel over-current hold with automatic retry, a thermal cut-off, a supply window with hysteresis, a per-channel DC-offset latch, and a per-half-bridge stuck-high guard. Any active protection pulls a single active-low fault summary low. The supply sample and the thermal flag each pass through a two-flop synchronizer. The supply is compared against attack and recover thresholds that arrive as inputs.

The supply window is a state machine with two states. SUP_LOW moves to SUP_OK when the synchronized sample is strictly above the attack level. SUP_OK moves back to SUP_LOW when the sample is strictly below the recover level. The over-current hold is also a state machine with two states, held per channel. OC_RUN moves to OC_HOLD when the flag is seen. OC_HOLD returns to OC_RUN when its timer reaches its last count and the flag is low. If the flag is still high at that point, the timer restarts and the state stays in OC_HOLD.

Top module: `bridge_guard`

## Requirements
- R1: While `run_en` is low, all gate enables are 0 and `fault_n` is 1. Every internal state returns to its initial value: the supply state is SUP_LOW, no holds are active and no latches are set.
- R2: While `play_en` is low, all gate enables are 0, and mute alone does not pull `fault_n` low. While `play_en` is high and no protection applies, `hs = pwm` and `ls = !pwm` for every half-bridge.
- R3: No half-bridge ever has its high-side and low-side enables at 1 together.
- R4: An over-current flag sampled high at one clock edge turns off all four enables of that channel and pulls `fault_n` low for exactly RETRY_CYC cycles. The other channel is unaffected. If the flag is still high when the hold ends, the hold restarts.
- R5: The thermal flag reaches the gating after two clock edges. While it is active, every enable is 0 and `fault_n` is 0. Release takes the same two edges.
- R6: The supply sample takes effect three edges after it changes. The state moves SUP_LOW to SUP_OK only when the sample is greater than `attack_lvl`, and SUP_OK to SUP_LOW only when it is less than `recover_lvl`. In SUP_LOW all enables are 0 and `fault_n` is 0.
- R7: When a channel's plus and minus PWM inputs differ at DC_CYC consecutive edges, that channel's enables turn off from the DC_CYC-th edge on. A single edge on which the inputs agree restarts the count.
- R8: The DC-offset latch, and its fault, stay set after the inputs agree again. The latch is cleared by the first edge on which `play_en` is high after being low, or by `run_en` low.
- R9: A PWM input sampled high on STUCK_CYC consecutive edges while `play_en` is high turns off that half-bridge and pulls `fault_n` low. Both release at the first edge after the input returns low.
- R10: While `run_en` is high, `fault_n` is 0 exactly when any protection of R4 to R9 is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| run_en | input | 1 | Standby control, low holds all logic in reset (asynchronous) |
| play_en | input | 1 | Mute control, low forces all outputs off |
| pwm_p | input | CH | Plus-side PWM input per channel |
| pwm_n | input | CH | Minus-side PWM input per channel |
| ocp_flag | input | CH | Over-current comparator flag per channel |
| hot_flag | input | 1 | Over-temperature flag (asynchronous) |
| vsup | input | VW | Digitized supply voltage sample (asynchronous) |
| attack_lvl | input | VW | Supply enable threshold |
| recover_lvl | input | VW | Supply disable threshold |
| hs_p | output | CH | High-side enable, plus half-bridge |
| ls_p | output | CH | Low-side enable, plus half-bridge |
| hs_n | output | CH | High-side enable, minus half-bridge |
| ls_n | output | CH | Low-side enable, minus half-bridge |
| fault_n | output | 1 | Active-low protection summary |

## Verification
The bench builds the block with RETRY_CYC=5, DC_CYC=12 and STUCK_CYC=20, so every timer boundary can be checked one cycle before and one cycle after it fires within a few dozen cycles. Because STUCK_CYC is larger than DC_CYC, a disagreeing pair trips the offset latch before the stuck-high guard can trip. With an 8-bit supply sample, all 256 values can be swept upward and then downward against a hysteresis model of the thresholds 112 and 96. Mute and the four PWM inputs are swept over all of their combinations.

// File: rtl/bg_pkg.sv
package bg_pkg;
    typedef enum logic {
        SUP_LOW = 1'b0,
        SUP_OK  = 1'b1
    } sup_state_t;

    typedef enum logic {
        OC_RUN  = 1'b0,
        OC_HOLD = 1'b1
    } oc_state_t;
endpackage

// File: rtl/bg_sync.sv
module bg_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/bg_oc_retry.sv
module bg_oc_retry
    import bg_pkg::*;
#(
    parameter int RETRY_CYC = 2500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic oc_in,
    output logic blocked
);
    localparam int CW = (RETRY_CYC > 1) ? $clog2(RETRY_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(RETRY_CYC - 1);

    oc_state_t     state, nxt;
    logic [CW-1:0] cnt, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= OC_RUN;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= cnt_d;
        end
    end

    always_comb begin
        nxt   = state;
        cnt_d = cnt;
        unique case (state)
            OC_RUN: begin
                if (oc_in) begin
                    nxt   = OC_HOLD;
                    cnt_d = '0;
                end
            end
            OC_HOLD: begin
                if (cnt == LAST) begin
                    if (oc_in) cnt_d = '0;
                    else       nxt   = OC_RUN;
                end else begin
                    cnt_d = cnt + CW'(1);
                end
            end
            default: nxt = OC_RUN;
        endcase
    end

    assign blocked = (state == OC_HOLD);
endmodule

// File: rtl/bg_dc_watch.sv
module bg_dc_watch #(
    parameter int DC_CYC = 37_500_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic in_p,
    input  logic in_n,
    output logic tripped
);
    localparam int CW = (DC_CYC > 1) ? $clog2(DC_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(DC_CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            tripped <= 1'b0;
        end else if (clr) begin
            cnt     <= '0;
            tripped <= 1'b0;
        end else if (!tripped) begin
            if (in_p == in_n) begin
                cnt <= '0;
            end else if (cnt == LAST) begin
                tripped <= 1'b1;
            end else begin
                cnt <= cnt + CW'(1);
            end
        end
    end
endmodule

// File: rtl/bg_hold_watch.sv
module bg_hold_watch #(
    parameter int STUCK_CYC = 25_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic level,
    output logic stuck
);
    localparam int CW = $clog2(STUCK_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(STUCK_CYC);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!arm || !level) begin
            cnt <= '0;
        end else if (cnt != LIMIT) begin
            cnt <= cnt + CW'(1);
        end
    end

    assign stuck = (cnt == LIMIT);
endmodule

// File: rtl/bridge_guard.sv
module bridge_guard
    import bg_pkg::*;
#(
    parameter int CH        = 2,
    parameter int VW        = 8,
    parameter int RETRY_CYC = 2500,
    parameter int DC_CYC    = 37_500_000,
    parameter int STUCK_CYC = 25_000
) (
    input  logic          clk,
    input  logic          run_en,
    input  logic          play_en,
    input  logic [CH-1:0] pwm_p,
    input  logic [CH-1:0] pwm_n,
    input  logic [CH-1:0] ocp_flag,
    input  logic          hot_flag,
    input  logic [VW-1:0] vsup,
    input  logic [VW-1:0] attack_lvl,
    input  logic [VW-1:0] recover_lvl,
    output logic [CH-1:0] hs_p,
    output logic [CH-1:0] ls_p,
    output logic [CH-1:0] hs_n,
    output logic [CH-1:0] ls_n,
    output logic          fault_n
);
    sup_state_t    sup_q, sup_d;
    logic [VW-1:0] vs_s;
    logic          hot_s;
    logic          play_q;
    logic          play_rise;
    logic          sup_ok;
    logic [CH-1:0] oc_blk, dc_trip, stuck_p, stuck_n;
    logic [CH-1:0] ch_go, p_go, n_go;

    bg_sync #(.W(VW)) u_vsync (
        .clk(clk), .rst_n(run_en), .d(vsup), .q(vs_s)
    );

    bg_sync #(.W(1)) u_tsync (
        .clk(clk), .rst_n(run_en), .d(hot_flag), .q(hot_s)
    );

    // supply window state register
    always_ff @(posedge clk or negedge run_en) begin
        if (!run_en) sup_q <= SUP_LOW;
        else         sup_q <= sup_d;
    end

    // supply window transitions
    always_comb begin
        sup_d = sup_q;
        unique case (sup_q)
            SUP_LOW: if (vs_s > attack_lvl)  sup_d = SUP_OK;
            SUP_OK:  if (vs_s < recover_lvl) sup_d = SUP_LOW;
            default: sup_d = SUP_LOW;
        endcase
    end

    always_ff @(posedge clk or negedge run_en) begin
        if (!run_en) play_q <= 1'b0;
        else         play_q <= play_en;
    end

    assign play_rise = play_en & ~play_q;
    assign sup_ok    = (sup_q == SUP_OK);

    for (genvar c = 0; c < CH; c++) begin : g_ch
        bg_oc_retry #(.RETRY_CYC(RETRY_CYC)) u_oc (
            .clk(clk), .rst_n(run_en), .oc_in(ocp_flag[c]), .blocked(oc_blk[c])
        );

        bg_dc_watch #(.DC_CYC(DC_CYC)) u_dc (
            .clk(clk), .rst_n(run_en), .clr(play_rise),
            .in_p(pwm_p[c]), .in_n(pwm_n[c]), .tripped(dc_trip[c])
        );

        bg_hold_watch #(.STUCK_CYC(STUCK_CYC)) u_hp (
            .clk(clk), .rst_n(run_en), .arm(play_en),
            .level(pwm_p[c]), .stuck(stuck_p[c])
        );

        bg_hold_watch #(.STUCK_CYC(STUCK_CYC)) u_hn (
            .clk(clk), .rst_n(run_en), .arm(play_en),
            .level(pwm_n[c]), .stuck(stuck_n[c])
        );

        assign ch_go[c] = play_en & sup_ok & ~hot_s & ~oc_blk[c] & ~dc_trip[c];
        assign p_go[c]  = ch_go[c] & ~stuck_p[c];
        assign n_go[c]  = ch_go[c] & ~stuck_n[c];
    end

    // output process
    always_comb begin
        for (int c = 0; c < CH; c++) begin
            hs_p[c] = p_go[c] &  pwm_p[c];
            ls_p[c] = p_go[c] & ~pwm_p[c];
            hs_n[c] = n_go[c] &  pwm_n[c];
            ls_n[c] = n_go[c] & ~pwm_n[c];
        end
        fault_n = ~(run_en & ((|oc_blk) | hot_s | ~sup_ok | (|dc_trip)
                              | (|stuck_p) | (|stuck_n)));
    end
endmodule

// File: rtl/bg_guard_chk.sv
module bg_guard_chk #(
    parameter int CH = 2
) (
    input logic          clk,
    input logic          run_en,
    input logic          play_en,
    input logic [CH-1:0] ocp_flag,
    input logic          hot_flag,
    input logic [CH-1:0] hs_p,
    input logic [CH-1:0] ls_p,
    input logic [CH-1:0] hs_n,
    input logic [CH-1:0] ls_n,
    input logic          fault_n
);
    logic [CH-1:0] any_on;
    assign any_on = hs_p | ls_p | hs_n | ls_n;

    // R1: standby keeps the bridge quiet and the fault released
    always @(negedge clk) begin
        if (!run_en) begin
            p_standby_quiet_r1: assert (any_on == '0 && fault_n)
                else $error("standby not quiet");
        end
    end

    p_mute_off_r2: assert property (@(posedge clk) disable iff (!run_en)
        !play_en |-> any_on == '0);

    p_no_shoot_r3: assert property (@(posedge clk) disable iff (!run_en)
        ((hs_p & ls_p) | (hs_n & ls_n)) == '0);

    for (genvar c = 0; c < CH; c++) begin : g_oc
        p_ocp_block_r4: assert property (@(posedge clk) disable iff (!run_en)
            ocp_flag[c] |=> (any_on[c] == 1'b0) && !fault_n);
    end

    p_hot_off_r5: assert property (@(posedge clk) disable iff (!run_en)
        ($past(run_en) && $past(hot_flag) && hot_flag) |=> (any_on == '0) && !fault_n);
endmodule

bind bridge_guard bg_guard_chk #(.CH(CH)) u_chk (
    .clk(clk), .run_en(run_en), .play_en(play_en), .ocp_flag(ocp_flag),
    .hot_flag(hot_flag), .hs_p(hs_p), .ls_p(ls_p), .hs_n(hs_n), .ls_n(ls_n),
    .fault_n(fault_n)
);

// File: tb/tb_bridge_guard.sv
module tb_bridge_guard;
    localparam int CH = 2, VW = 8, RETRY = 5, DCC = 12, STK = 20;
    localparam logic [7:0] ATT = 8'd112, REC = 8'd96;

    logic clk = 0;
    logic run_en, play_en, hot_flag;
    logic [CH-1:0] pwm_p, pwm_n, ocp_flag;
    logic [VW-1:0] vsup, attack_lvl, recover_lvl;
    logic [CH-1:0] hs_p, ls_p, hs_n, ls_n;
    logic fault_n;

    int checks = 0, failures = 0;
    bit done = 0;

    always #4 clk = ~clk;

    bridge_guard #(.CH(CH), .VW(VW), .RETRY_CYC(RETRY), .DC_CYC(DCC), .STUCK_CYC(STK)) dut (
        .clk(clk), .run_en(run_en), .play_en(play_en), .pwm_p(pwm_p), .pwm_n(pwm_n),
        .ocp_flag(ocp_flag), .hot_flag(hot_flag), .vsup(vsup), .attack_lvl(attack_lvl),
        .recover_lvl(recover_lvl), .hs_p(hs_p), .ls_p(ls_p), .hs_n(hs_n), .ls_n(ls_n),
        .fault_n(fault_n)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] expv(logic [1:0] gp, logic [1:0] gn, logic [1:0] pp, logic [1:0] pn);
        return {gp & pp, gp & ~pp, gn & pn, gn & ~pn};
    endfunction

    function automatic logic [7:0] obs();
        return {hs_p, ls_p, hs_n, ls_n};
    endfunction

    task automatic nedge(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        run_en = 0; play_en = 1; pwm_p = 2'b11; pwm_n = 2'b00; ocp_flag = 0; hot_flag = 0;
        vsup = 8'd200; attack_lvl = ATT; recover_lvl = REC;
        nedge(3);
        chk("R1 standby outputs", obs(), 8'h00);
        chk("R1 standby fault_n", fault_n, 1);

        // release standby, supply ramp latency
        pwm_p = 0;
        run_en = 1;
        nedge(2);
        chk("R6 supply not yet ok", obs(), 8'h00);
        chk("R6 fault while SUP_LOW", fault_n, 0);
        nedge(1);
        chk("R6 supply ok after 3 edges", obs(), 8'b00110011);
        chk("R10 fault clear", fault_n, 1);

        // exhaustive mute / pwm sweep
        for (int pl = 0; pl < 2; pl++) begin
            for (int pat = 0; pat < 16; pat++) begin
                @(negedge clk);
                play_en = pl[0]; pwm_p = pat[1:0]; pwm_n = pat[3:2];
                #1;
                chk("R2 mute/pwm sweep", obs(),
                    expv(pl[0] ? 2'b11 : 2'b00, pl[0] ? 2'b11 : 2'b00, pat[1:0], pat[3:2]));
                chk("R3 no shoot-through", {(hs_p & ls_p), (hs_n & ls_n)}, 0);
                chk("R2 mute is no fault", fault_n, 1);
            end
        end
        @(negedge clk); play_en = 1; pwm_p = 0; pwm_n = 0;
        nedge(2);

        // single over-current pulse on channel 0
        begin
            int off_n = 0, flt_n = 0, ch1_bad = 0;
            @(negedge clk); ocp_flag[0] = 1;
            @(negedge clk); ocp_flag[0] = 0;
            #1;
            for (int i = 0; i < 10; i++) begin
                if (i > 0) nedge(1);
                if (!ls_p[0] && !ls_n[0]) off_n++;
                if (!fault_n) flt_n++;
                if (!ls_p[1] || !ls_n[1]) ch1_bad++;
            end
            chk("R4 hold length", off_n, RETRY);
            chk("R4 fault length", flt_n, RETRY);
            chk("R4 other channel unaffected", ch1_bad, 0);
        end

        // persistent over-current on channel 1
        begin
            int bad = 0;
            @(negedge clk); ocp_flag[1] = 1;
            for (int i = 0; i < 13; i++) begin
                nedge(1);
                if (ls_p[1] || ls_n[1] || fault_n) bad++;
            end
            ocp_flag[1] = 0;
            chk("R4 retrigger while flag held", bad, 0);
            nedge(RETRY + 1);
            chk("R4 recovery after release", {ls_p[1], ls_n[1], fault_n}, 3'b111);
        end

        // thermal
        @(negedge clk); hot_flag = 1;
        nedge(1);
        chk("R5 thermal one edge still on", obs(), 8'b00110011);
        nedge(1);
        chk("R5 thermal off", obs(), 8'h00);
        chk("R5 thermal fault", fault_n, 0);
        hot_flag = 0;
        nedge(1);
        chk("R5 thermal release one edge", obs(), 8'h00);
        nedge(1);
        chk("R5 thermal released", obs(), 8'b00110011);

        // supply hysteresis sweep, up then down
        begin
            bit ok = 1;
            for (int d = 0; d < 2; d++) begin
                for (int k = 0; k < 256; k++) begin
                    int v = (d == 0) ? k : 255 - k;
                    @(negedge clk); vsup = v[7:0];
                    if (ok && v < REC) ok = 0;
                    else if (!ok && v > ATT) ok = 1;
                    nedge(3);
                    chk("R6 supply hysteresis", {ls_p[0], fault_n}, {ok, ok});
                end
            end
            @(negedge clk); vsup = 8'd200;
            nedge(4);
            chk("R6 supply back ok", obs(), 8'b00110011);
        end

        // DC offset on channel 0
        @(negedge clk); pwm_p[0] = 1;
        nedge(DCC - 1);
        chk("R7 offset before limit", {hs_p[0], ls_n[0], fault_n}, 3'b111);
        nedge(1);
        chk("R7 offset tripped", {hs_p[0], ls_n[0], fault_n}, 3'b000);
        chk("R7 other channel on", {ls_p[1], ls_n[1]}, 2'b11);
        pwm_p[0] = 0;
        nedge(3);
        chk("R8 latch holds after agree", {ls_p[0], ls_n[0], fault_n}, 3'b000);
        play_en = 0;
        nedge(1);
        play_en = 1;
        nedge(1);
        chk("R8 cleared by mute cycle", {ls_p[0], ls_n[0], fault_n}, 3'b111);

        // disagreement broken by one agreeing edge
        pwm_p[0] = 1;
        nedge(DCC - 1);
        pwm_p[0] = 0;
        nedge(1);
        pwm_p[0] = 1;
        nedge(DCC - 1);
        chk("R7 count restarted", {hs_p[0], fault_n}, 2'b11);
        nedge(1);
        chk("R7 trips after full run", {hs_p[0], fault_n}, 2'b00);
        pwm_p[0] = 0;
        run_en = 0;
        nedge(1);
        chk("R1 standby quiet", {obs(), fault_n}, 9'h001);
        run_en = 1;
        nedge(3);
        chk("R8 cleared by standby", {obs(), fault_n}, {8'b00110011, 1'b1});

        // stuck-high on channel 1
        pwm_p[1] = 1; pwm_n[1] = 1;
        nedge(STK - 1);
        chk("R9 before stuck limit", {hs_p[1], hs_n[1], fault_n}, 3'b111);
        nedge(1);
        chk("R9 stuck tripped", {hs_p[1], hs_n[1], fault_n}, 3'b000);
        chk("R9 other channel on", {ls_p[0], ls_n[0]}, 2'b11);
        pwm_p[1] = 0; pwm_n[1] = 0;
        #1;
        chk("R9 held until edge", {ls_p[1], ls_n[1], fault_n}, 3'b000);
        nedge(1);
        chk("R9 released", {ls_p[1], ls_n[1], fault_n}, 3'b111);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule